// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status-Tagged Receive Queue

This block receives asynchronous serial characters on a single input line and stores each one, together with four status flags, in a 16-entry first-in/first-out queue. The bit timing comes from an external strobe that pulses sixteen times per bit period. The receiver validates the start bit, reads 5 to 8 data bits least significant first, and can also check an even or odd parity bit. It then checks one or two stop bits. Every stored character carries its own break, overrun, parity-error and framing-error flags, so software can tell exactly which character was affected.

A consumer reads the queue through a show-ahead port. The oldest entry is always visible while the queue is not empty, and a single-cycle read strobe removes it. The empty and full indications let the consumer poll the queue. If a character completes while the queue is full, that character is dropped, and the loss is reported on the next character that does get stored.

Top module: `serial_rx_stat`

## Requirements
- R1: A frame is a low start bit, then N data bits with N = 5 + cfg_len (cfg_len 0..3), least significant bit first, then an optional parity bit, then one stop bit (cfg_two_stop=0) or two stop bits (cfg_two_stop=1). The data sits in rd_data[N-1:0], and the upper bits of rd_data read zero.
- R2: A falling edge on the line starts a frame only if the line is still low at the 8th oversample tick after the edge was seen. Otherwise the receiver goes back to idle and stores nothing.
- R3: Each bit after the start bit lasts 16 oversample ticks and is sampled once, 16 ticks after the sample point of the bit before it.
- R4: When cfg_par_en=1, a parity bit follows the data. With cfg_par_odd=0 the data bits plus the parity bit must hold an even number of ones; with cfg_par_odd=1 they must hold an odd number. A mismatch sets rd_par on that entry.
- R5: If any stop bit is sampled low, rd_frm is set on that entry.
- R6: If every sampled position of a frame is low (start, data, parity and every stop bit), the entry is stored with rd_brk=1, rd_frm=1 and data 0. The receiver then waits for the line to go high, so a long low period produces exactly one entry.
- R7: If a frame completes while the queue is full and no entry is read in that cycle, the character is discarded. The next entry written to the queue carries rd_ovr=1; every other entry carries rd_ovr=0.
- R8: The queue holds 16 entries and returns them in arrival order. empty is 1 exactly when no entry is stored, full is 1 exactly when 16 entries are stored, and both read as empty=1, full=0 after reset.
- R9: A read strobe while the queue is empty has no effect.
- R10: While the queue is not empty and no read is strobed, the head entry on the read port stays unchanged, even when new entries are written behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rxd | input | 1 | Serial input line, idles high |
| os_tick | input | 1 | One-cycle strobe, sixteen per bit period |
| cfg_len | input | 2 | Data length select, 5 + value bits |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_par_en | input | 1 | 1 enables the parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_en | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry data |
| rd_brk | output | 1 | Head entry break flag |
| rd_ovr | output | 1 | Head entry overrun flag |
| rd_par | output | 1 | Head entry parity-error flag |
| rd_frm | output | 1 | Head entry framing-error flag |
| empty | output | 1 | Queue holds no entry |
| full | output | 1 | Queue holds 16 entries |

## Verification
The hardest state to reach is overrun. It needs sixteen complete serial frames stored and left unread, then a seventeenth frame finishing into a full queue. The bench sends those frames back to back without reading, confirms that full is set, and sends one more frame. It then frees exactly one slot and sends a further frame, so it can check that the overrun mark sits on that later entry while the dropped character never appears. A line held low for many frame times and a start pulse shorter than half a bit are the other directed cases. Random frames with random length, stop count, parity mode and corrupted parity or stop bits fill in the rest.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int MAXW = 8;

    typedef struct packed {
        logic            brk;
        logic            ovr;
        logic            perr;
        logic            ferr;
        logic [MAXW-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_phase_e;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_i;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/srx_deframer.sv
module srx_deframer
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic       tick_i,
    input  logic [1:0] len_i,
    input  logic       two_stop_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    output logic       done_o,
    output rx_entry_t  frame_o
);
    localparam int TW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    typedef struct packed {
        rx_phase_e       ph;
        logic [TW-1:0]   tcnt;
        logic [2:0]      bidx;
        logic [MAXW-1:0] shreg;
        logic            pacc;
        logic            allz;
        logic            perr;
        logic            ferr;
        logic            sidx;
        logic            done;
    } dfr_t;

    dfr_t s_d, s_q;
    logic bit_due;
    logic last_bit;

    assign bit_due  = (s_q.tcnt == TW'(OVS - 1));
    assign last_bit = (s_q.bidx == (3'(len_i) + 3'd4));

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (tick_i) begin
            case (s_q.ph)
                RX_IDLE: begin
                    if (!line_i) begin
                        s_d.ph   = RX_START;
                        s_d.tcnt = '0;
                    end
                end
                RX_START: begin
                    if (s_q.tcnt == TW'(HALF - 1)) begin
                        s_d.tcnt = '0;
                        if (!line_i) begin
                            s_d.ph    = RX_DATA;
                            s_d.bidx  = '0;
                            s_d.shreg = '0;
                            s_d.pacc  = 1'b0;
                            s_d.allz  = 1'b1;
                            s_d.perr  = 1'b0;
                            s_d.ferr  = 1'b0;
                            s_d.sidx  = 1'b0;
                        end else begin
                            s_d.ph = RX_IDLE;
                        end
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (bit_due) begin
                        s_d.tcnt              = '0;
                        s_d.shreg[s_q.bidx]   = line_i;
                        s_d.pacc              = s_q.pacc ^ line_i;
                        s_d.allz              = s_q.allz & ~line_i;
                        if (last_bit) begin
                            s_d.ph = par_en_i ? RX_PAR : RX_STOP;
                        end else begin
                            s_d.bidx = s_q.bidx + 3'd1;
                        end
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (bit_due) begin
                        s_d.tcnt = '0;
                        s_d.perr = (line_i != (s_q.pacc ^ par_odd_i));
                        s_d.allz = s_q.allz & ~line_i;
                        s_d.ph   = RX_STOP;
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (bit_due) begin
                        s_d.tcnt = '0;
                        s_d.ferr = s_q.ferr | ~line_i;
                        s_d.allz = s_q.allz & ~line_i;
                        if (two_stop_i && !s_q.sidx) begin
                            s_d.sidx = 1'b1;
                        end else begin
                            s_d.done = 1'b1;
                            s_d.ph   = line_i ? RX_IDLE : RX_HOLD;
                        end
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (line_i) s_d.ph = RX_IDLE;
                end
                default: s_d.ph = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= RX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o        = s_q.done;
    assign frame_o.brk   = s_q.allz;
    assign frame_o.ovr   = 1'b0;
    assign frame_o.perr  = s_q.perr;
    assign frame_o.ferr  = s_q.ferr;
    assign frame_o.data  = s_q.shreg;
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  rx_entry_t wdata_i,
    input  logic      pop_i,
    output rx_entry_t rdata_o,
    output logic      empty_o,
    output logic      full_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t      p_d, p_q;
    rx_entry_t mem_q [DEPTH];
    logic      pop_ok;
    logic      push_ok;

    assign empty_o = (p_q.wp == p_q.rp);
    assign full_o  = (p_q.wp[AW] != p_q.rp[AW]) &&
                     (p_q.wp[AW-1:0] == p_q.rp[AW-1:0]);
    assign pop_ok  = pop_i && !empty_o;
    assign push_ok = push_i && (!full_o || pop_ok);

    always_comb begin
        p_d = p_q;
        if (push_ok) p_d.wp = p_q.wp + 1'b1;
        if (pop_ok)  p_d.rp = p_q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[p_q.wp[AW-1:0]] <= wdata_i;
    end

    assign rdata_o = mem_q[p_q.rp[AW-1:0]];
endmodule

// File: rtl/serial_rx_stat.sv
module serial_rx_stat
    import srx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       os_tick,
    input  logic [1:0] cfg_len,
    input  logic       cfg_two_stop,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_brk,
    output logic       rd_ovr,
    output logic       rd_par,
    output logic       rd_frm,
    output logic       empty,
    output logic       full
);
    typedef struct packed {
        logic ovr_pend;
    } top_t;

    top_t      t_d, t_q;
    logic      line_s;
    logic      frame_done;
    rx_entry_t frame;
    rx_entry_t wentry;
    rx_entry_t head;
    logic      fifo_push;
    logic      pop_ok;

    srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rxd),
        .q_o   (line_s)
    );

    srx_deframer #(.OVS(OVS)) i_dfr (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_s),
        .tick_i     (os_tick),
        .len_i      (cfg_len),
        .two_stop_i (cfg_two_stop),
        .par_en_i   (cfg_par_en),
        .par_odd_i  (cfg_par_odd),
        .done_o     (frame_done),
        .frame_o    (frame)
    );

    assign pop_ok    = rd_en && !empty;
    assign fifo_push = frame_done && (!full || pop_ok);

    always_comb begin
        wentry     = frame;
        wentry.ovr = t_q.ovr_pend;
        t_d        = t_q;
        if (fifo_push)       t_d.ovr_pend = 1'b0;
        else if (frame_done) t_d.ovr_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    srx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (fifo_push),
        .wdata_i (wentry),
        .pop_i   (rd_en),
        .rdata_o (head),
        .empty_o (empty),
        .full_o  (full)
    );

    assign rd_data = head.data;
    assign rd_brk  = head.brk;
    assign rd_ovr  = head.ovr;
    assign rd_par  = head.perr;
    assign rd_frm  = head.ferr;
endmodule

// File: rtl/serial_rx_stat_chk.sv
module serial_rx_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       rd_brk,
    input logic       rd_ovr,
    input logic       rd_par,
    input logic       rd_frm,
    input logic       empty,
    input logic       full,
    input logic       fifo_push
);
    a_r8_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        full && !rd_en |=> full);

    a_r9_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        empty && !fifo_push |=> empty);

    a_r6_break_shape: assert property (@(posedge clk) disable iff (!rst_n)
        !empty && rd_brk |-> rd_frm && (rd_data == 8'h00));

    a_r10_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !empty && !rd_en |=> $stable({rd_brk, rd_ovr, rd_par, rd_frm, rd_data}));
endmodule

bind serial_rx_stat serial_rx_stat_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_brk    (rd_brk),
    .rd_ovr    (rd_ovr),
    .rd_par    (rd_par),
    .rd_frm    (rd_frm),
    .empty     (empty),
    .full      (full),
    .fifo_push (fifo_push)
);

// File: tb/test_serial_rx_stat.sv
module test_serial_rx_stat;
    localparam int TICKDIV = 4;
    localparam int BITCLK  = 16 * TICKDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_brk, rd_ovr, rd_par, rd_frm, empty, full;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;
    int tdiv = 0;
    logic [11:0] exp_q[$];

    always #5 clk = ~clk;

    always_ff @(posedge clk) tdiv <= (tdiv == TICKDIV - 1) ? 0 : tdiv + 1;
    assign os_tick = (tdiv == 0);

    serial_rx_stat i_serial_rx_stat (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
        .cfg_len(cfg_len), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_en(rd_en), .rd_data(rd_data), .rd_brk(rd_brk), .rd_ovr(rd_ovr),
        .rd_par(rd_par), .rd_frm(rd_frm), .empty(empty), .full(full)
    );

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bit_time(input logic v);
        rxd = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    function automatic logic [11:0] expect_entry(input logic [7:0] d, input logic [1:0] len,
            input logic two, input logic pen, input logic podd, input logic flip,
            input logic bad, input logic ovr);
        logic [7:0] m;
        logic       pb;
        logic       brk;
        m   = d & ((8'd1 << (len + 5)) - 8'd1);
        pb  = (^m) ^ podd ^ flip;
        brk = (m == 8'd0) && (!pen || !pb) && bad && !two;
        return {brk, ovr, pen & flip, bad, m};
    endfunction

    task automatic send_frame(input logic [7:0] d, input logic [1:0] len, input logic two,
            input logic pen, input logic podd, input logic flip, input logic bad,
            input logic ovr, input logic drop);
        logic [7:0] m;
        m = d & ((8'd1 << (len + 5)) - 8'd1);
        cfg_len = len; cfg_two_stop = two; cfg_par_en = pen; cfg_par_odd = podd;
        bit_time(1'b0);
        for (int i = 0; i < int'(len) + 5; i++) bit_time(m[i]);
        if (pen) bit_time((^m) ^ podd ^ flip);
        bit_time(!bad);
        if (two) bit_time(1'b1);
        if (bad) bit_time(1'b1);
        if (!drop) exp_q.push_back(expect_entry(d, len, two, pen, podd, flip, bad, ovr));
    endtask

    task automatic pop_check(input string tag);
        logic [11:0] e;
        check(tag, {11'd0, empty}, 12'd0);
        e = exp_q.pop_front();
        check(tag, {rd_brk, rd_ovr, rd_par, rd_frm, rd_data}, e);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain(input string tag);
        while (exp_q.size() > 0) pop_check(tag);
        check(tag, {11'd0, empty}, 12'd1);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R8 reset state
        check("R8", {10'd0, empty, full}, 12'b10);

        // R9 read strobe while empty has no effect
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
        check("R9", {10'd0, empty, full}, 12'b10);
        send_frame(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drain("R9");

        // R1 5-bit frame, upper data bits zero
        send_frame(8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drain("R1");

        // R3 two stop bits, 8 data bits, odd parity
        send_frame(8'hA5, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(8'h5A, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drain("R3");

        // R4 parity error in both modes
        send_frame(8'h81, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        send_frame(8'h0E, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        drain("R4");

        // R5 stop bit low, nonzero data
        send_frame(8'h77, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        drain("R5");

        // R2 short low pulse is rejected
        cfg_len = 2'd3; cfg_two_stop = 1'b0; cfg_par_en = 1'b0;
        rxd = 1'b0; repeat (3 * TICKDIV) @(negedge clk);
        rxd = 1'b1; repeat (3 * BITCLK) @(negedge clk);
        check("R2", {11'd0, empty}, 12'd1);
        send_frame(8'hC3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drain("R2");

        // R6 long break yields one entry
        rxd = 1'b0; repeat (40 * BITCLK) @(negedge clk);
        rxd = 1'b1; repeat (2 * BITCLK) @(negedge clk);
        exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b1, 8'h00});
        drain("R6");

        // R7 / R8 overrun: 16 stored, 17th dropped, next stored gets the mark
        for (int i = 0; i < 16; i++)
            send_frame(8'(i * 13 + 1), 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8", {10'd0, empty, full}, 12'b01);
        send_frame(8'hEE, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R7", {10'd0, empty, full}, 12'b01);
        pop_check("R8");
        send_frame(8'h42, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        drain("R7");

        // random batches
        for (int b = 0; b < 20; b++) begin
            int n;
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) begin
                logic [7:0] d;
                logic [1:0] len;
                logic two, pen, podd, flip, bad;
                d    = 8'($urandom);
                len  = 2'($urandom);
                two  = 1'($urandom);
                pen  = 1'($urandom);
                podd = 1'($urandom);
                flip = ($urandom % 5) == 0;
                bad  = ($urandom % 6) == 0;
                send_frame(d, len, two, pen, podd, flip, bad, 1'b0, 1'b0);
            end
            drain("R1");
        end

        finish_run();
    end
endmodule